// File: doc/BRIEF.md
# Segmented Pipelined Content-Addressable Memory

This block is a small content-addressable memory with three operations on one port: read an entry by address, write an entry by address, and search all entries for a key. A search is the main operation. The key is first captured in a search register. Each stored word's comparison is then broken into four segments, and one segment is evaluated per pipeline stage. A word goes on to its next segment only if all of its earlier segments agreed with the key. The first segment is deliberately narrow (three bits by default), so most words drop out after one cheap compare.

After the last stage, a priority encoder returns whether any entry matched, the lowest matching index, and a flag for more than one match. A search may be issued on every cycle. For each stage, the block exposes which entries' segment comparisons were enabled in that cycle. It also exposes which local search-line groups (pairs of neighbouring entries by default) had to be driven. This lets power models count the comparisons and search-line toggles that the early kill saved.

A search compares against the table contents present when it was issued. A write that lands while older searches are still in flight does not affect them.

Top module: `cam_segml`

## Requirements
- R1: After reset, no entry is valid. A read reports the entry as not live, and a search reports no hit.
- R2: The op code is 0 idle, 1 read, 2 write, 3 search. A read of address A raises `rd_valid` exactly one cycle later, with that entry's data on `rd_data` and its valid bit on `rd_live`. A write sets the entry's data and its valid bit.
- R3: A search raises `res_valid` exactly five cycles after it is presented: one search-register cycle plus one per segment. Searches on consecutive cycles each produce their own result on consecutive cycles.
- R4: `res_hit` is set only when some valid entry equals the key in all 32 bits. `res_addr` is then the lowest such index; otherwise `res_addr` is 0.
- R5: `res_multi` is set exactly when two or more valid entries equal the key.
- R6: Bit k*8+e of `seg_en` is set when entry e's segment-k comparison is enabled in that cycle. Stage k of a search is shown k+1 cycles after the search is presented. An entry is enabled in stage k+1 only if it was enabled in stage k and its segment k equalled the key.
- R7: Segment 0 is bits 2:0, segment 1 is bits 12:3, segment 2 is bits 22:13 and segment 3 is bits 31:23. Stage k compares only segment k, so a difference in bit 0 removes an entry after stage 0, and a difference in bit 31 removes it only at the result.
- R8: Bit k*4+g of `lsl_drive` is set exactly when entry 2g or entry 2g+1 is enabled in stage k. Otherwise that local search-line group stays idle.
- R9: Entries that were invalid when a search was issued are never enabled in any stage and never match.
- R10: A write issued after a search, while that search is still in the pipeline, does not change that search's result. Searches issued after the write see the new contents.
- R11: Idle, read and write operations produce no `res_valid` and no segment enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Operation code: 0 idle, 1 read, 2 write, 3 search |
| addr | input | 3 | Entry address for read and write |
| wdata | input | 32 | Data for a write |
| key | input | 32 | Search key |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Data of the entry read |
| rd_live | output | 1 | Valid bit of the entry read |
| res_valid | output | 1 | Search result valid |
| res_hit | output | 1 | At least one entry matched |
| res_multi | output | 1 | Two or more entries matched |
| res_addr | output | 3 | Lowest matching index |
| seg_en | output | 32 | Per-stage entry comparison enables, stage-major |
| lsl_drive | output | 16 | Per-stage local search-line group drive, stage-major |

## Verification
The checker watches on every cycle the fixed five-cycle result timing, the one-cycle read timing, and the rule that a stage's enables are a subset of the previous stage's enables one cycle earlier. It also checks that each local group's drive agrees with the enables of its two entries, and that the hit and multi flags are consistent. What cannot be seen cycle by cycle is which entries should survive each segment, the lowest-index choice, invalid-entry exclusion, and the ordering of a write against in-flight searches. The bench's scenarios show these by predicting every stage's enables and every result from its own table model, which includes words that differ in a single bit at each segment boundary.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_SEARCH = 2'd3
    } cam_op_e;

    // Lowest bit of segment k: segment 0 is w0 bits wide and the rest of
    // the word is split evenly (rounded up) over the remaining segments.
    function automatic int seg_lo(int k, int w, int w0, int nseg);
        int step;
        int lo;
        if (k == 0) return 0;
        step = (w - w0 + nseg - 2) / (nseg - 1);
        lo   = w0 + (k - 1) * step;
        return (lo < w) ? lo : w;
    endfunction

    // One past the highest bit of segment k.
    function automatic int seg_hi(int k, int w, int w0, int nseg);
        if (k >= nseg - 1) return w;
        return seg_lo(k + 1, w, w0, nseg);
    endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  cam_op_e                        op,
    input  logic [AW-1:0]                  addr,
    input  logic [WIDTH-1:0]               wdata,
    output logic [ENTRIES-1:0][WIDTH-1:0]  tbl_data,
    output logic [ENTRIES-1:0]             tbl_vld,
    output logic                           rd_valid,
    output logic [WIDTH-1:0]               rd_data,
    output logic                           rd_live
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_data <= '0;
            tbl_vld  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_live  <= 1'b0;
        end else begin
            rd_valid <= (op == OP_READ);
            if (op == OP_READ) begin
                rd_data <= tbl_data[addr];
                rd_live <= tbl_vld[addr];
            end
            if (op == OP_WRITE) begin
                tbl_data[addr] <= wdata;
                tbl_vld[addr]  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cam_seg_stage.sv
module cam_seg_stage
    import cam_pkg::*;
#(
    parameter int ENTRIES      = 8,
    parameter int WIDTH        = 32,
    parameter int NSEG         = 4,
    parameter int SEG0_W       = 3,
    parameter int IDX          = 0,
    parameter int ROWS_PER_LSL = 2,
    localparam int NGRP        = ENTRIES / ROWS_PER_LSL
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           v_i,
    input  logic [WIDTH-1:0]               key_i,
    input  logic [ENTRIES-1:0][WIDTH-1:0]  snap_i,
    input  logic [ENTRIES-1:0]             alive_i,
    output logic                           v_o,
    output logic [ENTRIES-1:0]             alive_o,
    output logic [ENTRIES-1:0]             en_o,
    output logic [NGRP-1:0]                grp_o
);

    localparam int LO = seg_lo(IDX, WIDTH, SEG0_W, NSEG);
    localparam int HI = seg_hi(IDX, WIDTH, SEG0_W, NSEG);
    localparam logic [WIDTH-1:0] ONES = '1;
    localparam logic [WIDTH-1:0] MASK = (ONES << LO) & ~(ONES << HI);

    logic [ENTRIES-1:0] seg_ok;

    // Only entries whose match line is still alive take part this cycle.
    assign en_o = alive_i & {ENTRIES{v_i}};

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            seg_ok[e] = ((key_i ^ snap_i[e]) & MASK) == '0;
        end
    end

    // A local search-line group is driven only if one of its rows is alive.
    for (genvar g = 0; g < NGRP; g++) begin : g_lsl
        assign grp_o[g] = |en_o[g*ROWS_PER_LSL +: ROWS_PER_LSL];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o     <= 1'b0;
            alive_o <= '0;
        end else begin
            v_o     <= v_i;
            alive_o <= en_o & seg_ok;
        end
    end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N   = 8,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic          multi,
    output logic [AW-1:0] idx
);

    logic [AW:0] cnt;

    always_comb begin
        idx = '0;
        cnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
        for (int i = 0; i < N; i++) begin
            cnt = cnt + (AW+1)'(req[i]);
        end
        any   = |req;
        multi = cnt > (AW+1)'(1);
    end

endmodule

// File: rtl/cam_segml.sv
module cam_segml
    import cam_pkg::*;
#(
    parameter int ENTRIES      = 8,
    parameter int WIDTH        = 32,
    parameter int NSEG         = 4,
    parameter int SEG0_W       = 3,
    parameter int ROWS_PER_LSL = 2,
    localparam int AW          = $clog2(ENTRIES),
    localparam int NGRP        = ENTRIES / ROWS_PER_LSL
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                op,
    input  logic [AW-1:0]             addr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [WIDTH-1:0]          key,
    output logic                      rd_valid,
    output logic [WIDTH-1:0]          rd_data,
    output logic                      rd_live,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic                      res_multi,
    output logic [AW-1:0]             res_addr,
    output logic [NSEG*ENTRIES-1:0]   seg_en,
    output logic [NSEG*NGRP-1:0]      lsl_drive
);

    cam_op_e op_e;
    assign op_e = cam_op_e'(op);

    logic [ENTRIES-1:0][WIDTH-1:0] tbl_data;
    logic [ENTRIES-1:0]            tbl_vld;

    cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .op       (op_e),
        .addr     (addr),
        .wdata    (wdata),
        .tbl_data (tbl_data),
        .tbl_vld  (tbl_vld),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_live  (rd_live)
    );

    // Search register plus the key/table pipe that follows each search.
    logic                                     sreg_v;
    logic [ENTRIES-1:0]                       sreg_alive;
    logic [NSEG-1:0][WIDTH-1:0]               pkey;
    logic [NSEG-1:0][ENTRIES-1:0][WIDTH-1:0]  psnap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_v     <= 1'b0;
            sreg_alive <= '0;
        end else begin
            sreg_v     <= (op_e == OP_SEARCH);
            sreg_alive <= (op_e == OP_SEARCH) ? tbl_vld : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (op_e == OP_SEARCH) begin
            pkey[0]  <= key;
            psnap[0] <= tbl_data;
        end
        for (int k = 1; k < NSEG; k++) begin
            pkey[k]  <= pkey[k-1];
            psnap[k] <= psnap[k-1];
        end
    end

    logic [NSEG-1:0]               st_v;
    logic [NSEG-1:0][ENTRIES-1:0]  st_alive;
    logic [NSEG-1:0][ENTRIES-1:0]  st_en;
    logic [NSEG-1:0][NGRP-1:0]     st_grp;

    for (genvar k = 0; k < NSEG; k++) begin : g_stage
        logic               v_in;
        logic [ENTRIES-1:0] a_in;
        if (k == 0) begin : g_first
            assign v_in = sreg_v;
            assign a_in = sreg_alive;
        end else begin : g_next
            assign v_in = st_v[k-1];
            assign a_in = st_alive[k-1];
        end

        cam_seg_stage #(
            .ENTRIES      (ENTRIES),
            .WIDTH        (WIDTH),
            .NSEG         (NSEG),
            .SEG0_W       (SEG0_W),
            .IDX          (k),
            .ROWS_PER_LSL (ROWS_PER_LSL)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .v_i     (v_in),
            .key_i   (pkey[k]),
            .snap_i  (psnap[k]),
            .alive_i (a_in),
            .v_o     (st_v[k]),
            .alive_o (st_alive[k]),
            .en_o    (st_en[k]),
            .grp_o   (st_grp[k])
        );
    end

    assign seg_en    = st_en;
    assign lsl_drive = st_grp;
    assign res_valid = st_v[NSEG-1];

    cam_prio_enc #(.N(ENTRIES)) u_enc (
        .req   (st_alive[NSEG-1]),
        .any   (res_hit),
        .multi (res_multi),
        .idx   (res_addr)
    );

endmodule

// File: rtl/cam_segml_chk.sv
module cam_segml_chk #(
    parameter int ENTRIES      = 8,
    parameter int NSEG         = 4,
    parameter int ROWS_PER_LSL = 2,
    localparam int NGRP        = ENTRIES / ROWS_PER_LSL
) (
    input logic                     clk,
    input logic                     rst,
    input logic [1:0]               op,
    input logic                     rd_valid,
    input logic                     res_valid,
    input logic                     res_hit,
    input logic                     res_multi,
    input logic [NSEG*ENTRIES-1:0]  seg_en,
    input logic [NSEG*NGRP-1:0]     lsl_drive
);

    // Track issued searches so the result window needs no deep $past.
    logic [NSEG:0] issue_q;
    always_ff @(posedge clk) begin
        if (rst) issue_q <= '0;
        else     issue_q <= {issue_q[NSEG-1:0], op == 2'd3};
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        res_valid == issue_q[NSEG]);

    p_read_timing_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid == ($past(op) == 2'd1 && !$past(rst)));

    p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    p_multi_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
        res_multi |-> res_hit);

    for (genvar k = 1; k < NSEG; k++) begin : g_kill
        p_stage_kill_r6: assert property (@(posedge clk) disable iff (rst)
            (seg_en[k*ENTRIES +: ENTRIES] & ~$past(seg_en[(k-1)*ENTRIES +: ENTRIES])) == '0);
    end

    for (genvar k = 0; k < NSEG; k++) begin : g_lk
        for (genvar g = 0; g < NGRP; g++) begin : g_lg
            p_lsl_gate_r8: assert property (@(posedge clk) disable iff (rst)
                lsl_drive[k*NGRP + g] == |seg_en[k*ENTRIES + g*ROWS_PER_LSL +: ROWS_PER_LSL]);
        end
    end

endmodule

bind cam_segml cam_segml_chk #(
    .ENTRIES      (ENTRIES),
    .NSEG         (NSEG),
    .ROWS_PER_LSL (ROWS_PER_LSL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .rd_valid  (rd_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_multi (res_multi),
    .seg_en    (seg_en),
    .lsl_drive (lsl_drive)
);

// File: tb/sim_cam_segml.sv
module sim_cam_segml;

    localparam int CLK_NS = 10;
    localparam int E  = 8;
    localparam int W  = 32;
    localparam int S  = 4;
    localparam int G  = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    op = 2'd0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  key = '0;
    logic          rd_valid, rd_live, res_valid, res_hit, res_multi;
    logic [W-1:0]  rd_data;
    logic [AW-1:0] res_addr;
    logic [S*E-1:0] seg_en;
    logic [S*G-1:0] lsl_drive;

    cam_segml u0 (
        .clk(clk), .rst(rst), .op(op), .addr(addr), .wdata(wdata), .key(key),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_live(rd_live),
        .res_valid(res_valid), .res_hit(res_hit), .res_multi(res_multi),
        .res_addr(res_addr), .seg_en(seg_en), .lsl_drive(lsl_drive)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  nchecks = 0;
    int  nerr    = 0;
    bit  done    = 0;

    // Reference table.
    bit [W-1:0] m_data [E];
    bit [E-1:0] m_vld;

    // Expectations ring, indexed by issue cycle.
    bit             r_cmp   [8];
    bit [S-1:0][E-1:0] r_en [8];
    bit             r_hit   [8];
    bit             r_multi [8];
    bit [AW-1:0]    r_addr  [8];
    string          r_tag   [8];
    bit             r_rd    [8];
    bit [W-1:0]     r_rdata [8];
    bit             r_rlive [8];
    string          r_rtag  [8];

    // R7 segment boundaries.
    function automatic int seg_of(int b);
        return (b < 3) ? 0 : 1 + (b - 3) / 10;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic check_now();
        for (int k = 0; k < S; k++) begin
            int src = cyc - 1 - k;
            bit [E-1:0] e_en = '0;
            bit [G-1:0] e_g;
            if (src >= 0 && r_cmp[src % 8]) e_en = r_en[src % 8][k];
            chk(seg_en[k*E +: E] == e_en, "R6 R7 R9 R11", $sformatf("stage %0d enables", k),
                longint'(seg_en[k*E +: E]), longint'(e_en));
            for (int g = 0; g < G; g++) e_g[g] = |e_en[g*2 +: 2];
            chk(lsl_drive[k*G +: G] == e_g, "R8", $sformatf("stage %0d group drive", k),
                longint'(lsl_drive[k*G +: G]), longint'(e_g));
        end
        begin
            int src = cyc - 5;
            bit ev = (src >= 0) && r_cmp[src % 8];
            chk(res_valid == ev, "R3 R11", "res_valid", longint'(res_valid), longint'(ev));
            if (ev && res_valid) begin
                int i = src % 8;
                chk(res_hit == r_hit[i], r_tag[i], "res_hit", longint'(res_hit), longint'(r_hit[i]));
                chk(res_addr == r_addr[i], r_tag[i], "res_addr", longint'(res_addr), longint'(r_addr[i]));
                chk(res_multi == r_multi[i], "R5", "res_multi", longint'(res_multi), longint'(r_multi[i]));
            end
        end
        begin
            int src = cyc - 1;
            bit ev = (src >= 0) && r_rd[src % 8];
            chk(rd_valid == ev, "R2", "rd_valid", longint'(rd_valid), longint'(ev));
            if (ev && rd_valid) begin
                int i = src % 8;
                chk(rd_data == r_rdata[i], r_rtag[i], "rd_data", longint'(rd_data), longint'(r_rdata[i]));
                chk(rd_live == r_rlive[i], r_rtag[i], "rd_live", longint'(rd_live), longint'(r_rlive[i]));
            end
        end
    endtask

    task automatic step(bit [1:0] o, int a, bit [W-1:0] d, bit [W-1:0] k, string tag);
        int i;
        @(negedge clk);
        check_now();
        op = o; addr = AW'(a); wdata = d; key = k;
        i = cyc % 8;
        r_cmp[i] = (o == 2'd3);
        r_rd[i]  = (o == 2'd1);
        r_tag[i] = tag;
        r_rtag[i] = tag;
        if (o == 2'd3) begin
            bit [E-1:0] alive = m_vld;
            for (int s = 0; s < S; s++) begin
                r_en[i][s] = alive;
                for (int e = 0; e < E; e++)
                    for (int b = 0; b < W; b++)
                        if (seg_of(b) == s && m_data[e][b] != k[b]) alive[e] = 1'b0;
            end
            r_hit[i]   = |alive;
            r_multi[i] = $countones(alive) > 1;
            r_addr[i]  = '0;
            for (int e = E - 1; e >= 0; e--) if (alive[e]) r_addr[i] = AW'(e);
        end
        if (o == 2'd1) begin
            r_rdata[i] = m_data[a];
            r_rlive[i] = m_vld[a];
        end
        if (o == 2'd2) begin
            m_data[a] = d;
            m_vld[a]  = 1'b1;
        end
    endtask

    task automatic idle(int n);
        for (int j = 0; j < n; j++) step(2'd0, 0, '0, '0, "R11");
    endtask

    function automatic bit [W-1:0] pick_word();
        int r = $urandom_range(0, 3);
        bit [W-1:0] base = m_data[$urandom_range(0, E-1)];
        case (r)
            0: return W'($urandom());
            1: return base;
            2: return base ^ (W'(1) << $urandom_range(0, W-1));
            default: return base ^ (W'(1) << $urandom_range(0, 2));
        endcase
    endfunction

    localparam bit [W-1:0] A = 32'hC3A5_5A3C;
    localparam bit [W-1:0] B = 32'h1234_5678;

    initial begin
        void'($urandom(32'h5eed));
        for (int e = 0; e < E; e++) begin m_data[e] = '0; end
        m_vld = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty table after reset.
        idle(2);
        step(2'd3, 0, '0, '0, "R1");
        step(2'd1, 3, '0, '0, "R1");
        idle(6);

        // R2: write then read back.
        step(2'd2, 0, A, '0, "R2");
        step(2'd1, 0, '0, '0, "R2");
        step(2'd2, 1, A, '0, "R2");
        step(2'd2, 2, A ^ 32'h0000_0001, '0, "R2");
        step(2'd2, 3, A ^ 32'h8000_0000, '0, "R2");
        step(2'd2, 5, A ^ 32'h0000_1000, '0, "R2");
        step(2'd2, 6, A ^ 32'h0000_2000, '0, "R2");
        step(2'd1, 7, '0, '0, "R2");

        // R4 R5 R7 R9: multi-hit, boundary bits, invalid entries 4 and 7.
        step(2'd3, 0, '0, A, "R4");
        step(2'd3, 0, '0, A ^ 32'h8000_0000, "R4");
        step(2'd3, 0, '0, A ^ 32'h0000_2000, "R4");
        step(2'd3, 0, '0, A ^ 32'h0000_0004, "R4");
        idle(6);

        // R10: writes behind in-flight searches.
        step(2'd3, 0, '0, A, "R10");
        step(2'd2, 0, B, '0, "R10");
        step(2'd2, 1, B, '0, "R10");
        step(2'd3, 0, '0, A, "R10");
        step(2'd3, 0, '0, B, "R10");
        idle(6);

        // Random mix with back-to-back searches (R3).
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 40)      step(2'd3, 0, '0, pick_word(), "R3 R4");
            else if (r < 65) step(2'd2, $urandom_range(0, E-1), pick_word(), '0, "R2");
            else if (r < 85) step(2'd1, $urandom_range(0, E-1), '0, '0, "R2");
            else             step(2'd0, 0, '0, '0, "R11");
        end
        idle(8);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

endmodule